// File: doc/BRIEF.md
# PCM Time-Slot Slip Buffer

This block takes bytes that a line decoder delivers at a 64 kbit/s rate and replays each one as eight serial bits inside one chosen time-slot of a 2.048 Mbit/s PCM stream. The write side and the read side run from clocks that are not locked to each other. A two-entry ping-pong store absorbs their drift: each new byte lands in the register that is not currently offered to the reader, and the reader always takes the most recently completed byte.

When the reader starts a slot and nothing new has arrived, the previous byte is sent again and a repeat flag is raised. When two or more bytes arrived since the last slot, only the newest is sent, the older ones are lost, and a drop flag is raised. Each flag is updated at the start of a slot and then holds until the next slot starts, so it stays up for one frame. Two slot strobes are offered and a select input picks one. The serial output is forced to all ones, the alarm indication pattern, on a blank request, or when a received alarm is present and alarm supervision is enabled.

All logic runs on one system clock. A one-cycle `bit_tick` enable marks each 2.048 MHz bit period. Writes are single-cycle `wr_valid` pulses.

Top module: `pcm_slot_buffer`

## Requirements
- R1: After reset, `pcm_out` is 1 and both `rep_flag` and `drop_flag` are 0.
- R2: A slot starts on a `bit_tick` cycle where the selected strobe is high and it was low at the previous `bit_tick`. From the clock edge of that cycle, `pcm_out` carries the byte most significant bit first. Each bit holds until the edge of the next `bit_tick`.
- R3: The edge of the ninth `bit_tick` of a slot returns `pcm_out` to 1, and it stays 1 until the next slot starts.
- R4: With `ts_pick` high, `ts_a` is the slot strobe; with `ts_pick` low, `ts_b` is. Edges on the strobe that is not selected start no slot and leave `pcm_out` and both flags unchanged.
- R5: When exactly one byte was written since the previous slot start, the slot sends that byte. From the slot start edge, both flags are 0.
- R6: When no byte was written since the previous slot start, the slot sends the last byte again. From the slot start edge, `rep_flag` is 1 and `drop_flag` is 0. Before any write, the stored byte is 8'hFF.
- R7: When two or more bytes were written since the previous slot start, the slot sends the newest one. From the slot start edge, `drop_flag` is 1 and `rep_flag` is 0.
- R8: A write in the same cycle as a slot start does not affect that slot. It counts as the first byte for the next slot.
- R9: While `blank_req` is 1, `pcm_out` is 1 in the same cycle. The buffer still consumes bytes and updates the flags.
- R10: While `sup_n` is 0 and `alarm_in` is 1, `pcm_out` is 1. While `sup_n` is 1, `alarm_in` has no effect on `pcm_out`.
- R11: Both flags change only at a slot start edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_valid | input | 1 | One-cycle pulse: a decoded byte is complete |
| wr_byte | input | 8 | Decoded byte, valid with `wr_valid` |
| bit_tick | input | 1 | One-cycle enable per PCM bit period |
| ts_pick | input | 1 | Strobe select: 1 picks `ts_a`, 0 picks `ts_b` |
| ts_a | input | 1 | First time-slot strobe |
| ts_b | input | 1 | Second time-slot strobe |
| blank_req | input | 1 | Forces all-ones output, active high |
| sup_n | input | 1 | Alarm supervision enable, active low |
| alarm_in | input | 1 | Received octet-timing alarm, active high |
| pcm_out | output | 1 | Serial PCM output |
| rep_flag | output | 1 | Byte repeated in the current frame |
| drop_flag | output | 1 | Byte dropped before the current frame |

## Verification
The most significant bit appears after the same clock edge that sees the slot start, so it is sampled one half clock after that `bit_tick`. Each later bit is sampled half a clock after its own tick. The flags come from a register loaded at that same edge, so they are sampled together with the first bit. Blanking is combinational and is checked half a clock after the inputs change. The idle level is checked after the ninth tick. Inputs change only on falling clock edges and outputs are read only on falling edges, so each sample sits half a period away from the register edge it depends on.

// File: rtl/pcm_slot_pkg.sv
package pcm_slot_pkg;

    parameter int unsigned BYTE_W = 8;

    // how many bytes have been written since the last slot start
    typedef enum logic [1:0] {
        PEND_NONE = 2'd0,
        PEND_ONE  = 2'd1,
        PEND_MANY = 2'd2
    } pend_e;

endpackage

// File: rtl/pcm_slot_detect.sv
module pcm_slot_detect (
    input  logic clk,
    input  logic rst_n,
    input  logic bit_tick,
    input  logic ts_pick,
    input  logic ts_a,
    input  logic ts_b,
    output logic frame_start
);

    typedef struct packed {
        logic prev;
    } det_t;

    det_t s_d, s_q;
    logic strobe;

    always_comb begin
        strobe      = ts_pick ? ts_a : ts_b;
        s_d         = s_q;
        frame_start = bit_tick & strobe & ~s_q.prev;
        if (bit_tick) begin
            s_d.prev = strobe;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '{prev: 1'b0};
        end else begin
            s_q <= s_d;
        end
    end

endmodule

// File: rtl/pcm_slip_store.sv
module pcm_slip_store
    import pcm_slot_pkg::*;
#(
    parameter int unsigned BYTE_W = pcm_slot_pkg::BYTE_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_valid,
    input  logic [BYTE_W-1:0] wr_byte,
    input  logic              rd_start,
    output logic [BYTE_W-1:0] rd_byte,
    output logic              rep_flag,
    output logic              drop_flag
);

    localparam int unsigned BANKS = 2;

    typedef struct packed {
        logic [BANKS-1:0][BYTE_W-1:0] bank;
        logic                         wsel;
        pend_e                        pend;
        logic                         rep;
        logic                         drop;
    } store_t;

    localparam store_t ST_RST = '{
        bank: '1,
        wsel: 1'b0,
        pend: PEND_NONE,
        rep:  1'b0,
        drop: 1'b0
    };

    store_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        // the read samples state as it was before any write in this cycle
        if (rd_start) begin
            s_d.rep  = (s_q.pend == PEND_NONE);
            s_d.drop = (s_q.pend == PEND_MANY);
            s_d.pend = PEND_NONE;
        end
        if (wr_valid) begin
            for (int i = 0; i < int'(BANKS); i++) begin
                if (i == int'(s_q.wsel)) begin
                    s_d.bank[i] = wr_byte;
                end
            end
            s_d.wsel = ~s_q.wsel;
            if (rd_start || s_q.pend == PEND_NONE) begin
                s_d.pend = PEND_ONE;
            end else begin
                s_d.pend = PEND_MANY;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= ST_RST;
        end else begin
            s_q <= s_d;
        end
    end

    // newest complete byte sits in the register not addressed for writing
    assign rd_byte   = s_q.bank[~s_q.wsel];
    assign rep_flag  = s_q.rep;
    assign drop_flag = s_q.drop;

endmodule

// File: rtl/pcm_slot_shifter.sv
module pcm_slot_shifter #(
    parameter int unsigned BYTE_W = pcm_slot_pkg::BYTE_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bit_tick,
    input  logic              load,
    input  logic [BYTE_W-1:0] load_byte,
    output logic              ser_bit,
    output logic              busy
);

    localparam int unsigned CW = (BYTE_W > 1) ? $clog2(BYTE_W) : 1;
    localparam logic [CW-1:0] LAST = CW'(BYTE_W - 1);

    typedef struct packed {
        logic [BYTE_W-1:0] sh;
        logic [CW-1:0]     cnt;
        logic              busy;
    } shf_t;

    shf_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        if (load) begin
            s_d.sh   = load_byte;
            s_d.cnt  = '0;
            s_d.busy = 1'b1;
        end else if (bit_tick && s_q.busy) begin
            if (s_q.cnt == LAST) begin
                s_d.busy = 1'b0;
            end else begin
                s_d.sh  = s_q.sh << 1;
                s_d.cnt = s_q.cnt + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '{sh: '1, cnt: '0, busy: 1'b0};
        end else begin
            s_q <= s_d;
        end
    end

    assign ser_bit = s_q.sh[BYTE_W-1];
    assign busy    = s_q.busy;

endmodule

// File: rtl/pcm_slot_buffer.sv
module pcm_slot_buffer
    import pcm_slot_pkg::*;
#(
    parameter int unsigned BYTE_W = pcm_slot_pkg::BYTE_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_valid,
    input  logic [BYTE_W-1:0] wr_byte,
    input  logic              bit_tick,
    input  logic              ts_pick,
    input  logic              ts_a,
    input  logic              ts_b,
    input  logic              blank_req,
    input  logic              sup_n,
    input  logic              alarm_in,
    output logic              pcm_out,
    output logic              rep_flag,
    output logic              drop_flag
);

    logic              frame_start;
    logic [BYTE_W-1:0] rd_byte;
    logic              ser_bit;
    logic              slot_busy;
    logic              force_ones;

    pcm_slot_detect u_detect (
        .clk         (clk),
        .rst_n       (rst_n),
        .bit_tick    (bit_tick),
        .ts_pick     (ts_pick),
        .ts_a        (ts_a),
        .ts_b        (ts_b),
        .frame_start (frame_start)
    );

    pcm_slip_store #(.BYTE_W(BYTE_W)) u_store (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_valid  (wr_valid),
        .wr_byte   (wr_byte),
        .rd_start  (frame_start),
        .rd_byte   (rd_byte),
        .rep_flag  (rep_flag),
        .drop_flag (drop_flag)
    );

    pcm_slot_shifter #(.BYTE_W(BYTE_W)) u_shift (
        .clk       (clk),
        .rst_n     (rst_n),
        .bit_tick  (bit_tick),
        .load      (frame_start),
        .load_byte (rd_byte),
        .ser_bit   (ser_bit),
        .busy      (slot_busy)
    );

    always_comb begin
        force_ones = blank_req | (~sup_n & alarm_in);
        pcm_out    = force_ones | ~slot_busy | ser_bit;
    end

endmodule

// File: rtl/pcm_slot_buffer_chk.sv
module pcm_slot_buffer_chk (
    input logic clk,
    input logic rst_n,
    input logic blank_req,
    input logic sup_n,
    input logic alarm_in,
    input logic pcm_out,
    input logic rep_flag,
    input logic drop_flag,
    input logic frame_start,
    input logic slot_busy
);

    // R9
    a_r9_blank_ones: assert property (@(posedge clk) disable iff (!rst_n)
        blank_req |-> pcm_out);

    // R10
    a_r10_alarm_ones: assert property (@(posedge clk) disable iff (!rst_n)
        (!sup_n && alarm_in) |-> pcm_out);

    // R11
    a_r11_flags_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !frame_start |=> ($stable(rep_flag) && $stable(drop_flag)));

    // R6 and R7: a slot cannot both repeat and drop
    a_r7_flags_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        !(rep_flag && drop_flag));

    // R2
    a_r2_slot_runs: assert property (@(posedge clk) disable iff (!rst_n)
        frame_start |=> slot_busy);

endmodule

bind pcm_slot_buffer pcm_slot_buffer_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .blank_req   (blank_req),
    .sup_n       (sup_n),
    .alarm_in    (alarm_in),
    .pcm_out     (pcm_out),
    .rep_flag    (rep_flag),
    .drop_flag   (drop_flag),
    .frame_start (frame_start),
    .slot_busy   (slot_busy)
);

// File: tb/pcm_slot_buffer_bench.sv
module pcm_slot_buffer_bench;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_valid = 1'b0;
    logic [7:0] wr_byte = 8'h00;
    logic       bit_tick = 1'b0;
    logic       ts_pick = 1'b1;
    logic       ts_a = 1'b0;
    logic       ts_b = 1'b0;
    logic       blank_req = 1'b0;
    logic       sup_n = 1'b1;
    logic       alarm_in = 1'b0;
    logic       pcm_out;
    logic       rep_flag;
    logic       drop_flag;

    int checks = 0;
    int errors = 0;

    // bench reference model
    logic [7:0] m_last = 8'hFF;
    int         m_cnt = 0;

    always #5 clk = ~clk;

    pcm_slot_buffer u_pcm_slot_buffer (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_valid  (wr_valid),
        .wr_byte   (wr_byte),
        .bit_tick  (bit_tick),
        .ts_pick   (ts_pick),
        .ts_a      (ts_a),
        .ts_b      (ts_b),
        .blank_req (blank_req),
        .sup_n     (sup_n),
        .alarm_in  (alarm_in),
        .pcm_out   (pcm_out),
        .rep_flag  (rep_flag),
        .drop_flag (drop_flag)
    );

    task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s actual %0h expected %0h", req, got, exp);
        end
    endtask

    function automatic logic forced_ones(input logic blk, input logic sn, input logic al);
        return blk | (~sn & al);
    endfunction

    task automatic model_write(input logic [7:0] b);
        m_last = b;
        m_cnt  = m_cnt + 1;
    endtask

    task automatic write_byte(input logic [7:0] b);
        @(negedge clk);
        wr_valid = 1'b1;
        wr_byte  = b;
        @(negedge clk);
        wr_valid = 1'b0;
        model_write(b);
    endtask

    task automatic drive_strobe(input logic pick, input logic v);
        if (pick) ts_a = v;
        else      ts_b = v;
    endtask

    // one bit period of four clocks; pcm_out sampled after the tick edge
    task automatic bit_period(input logic pick, input logic v, input logic wr_now,
                              input logic [7:0] wb, output logic smp);
        @(negedge clk);
        bit_tick = 1'b1;
        drive_strobe(pick, v);
        if (wr_now) begin
            wr_valid = 1'b1;
            wr_byte  = wb;
        end
        @(negedge clk);
        bit_tick = 1'b0;
        wr_valid = 1'b0;
        smp = pcm_out;
        @(negedge clk);
        @(negedge clk);
    endtask

    task automatic read_slot(input string req, input logic pick,
                             input logic wr_now, input logic [7:0] wb);
        logic [7:0] got;
        logic       smp;
        logic [7:0] eb;
        logic       er;
        logic       ed;
        logic       rf;
        logic       df;
        ts_pick = pick;
        bit_period(pick, 1'b0, 1'b0, 8'h00, smp);
        eb = forced_ones(blank_req, sup_n, alarm_in) ? 8'hFF : m_last;
        er = (m_cnt == 0);
        ed = (m_cnt >= 2);
        m_cnt = 0;
        rf = 1'b0;
        df = 1'b0;
        for (int i = 0; i < 8; i++) begin
            bit_period(pick, 1'b1, wr_now && (i == 0), wb, smp);
            got[7-i] = smp;
            if (i == 0) begin
                rf = rep_flag;
                df = drop_flag;
            end
        end
        if (wr_now) model_write(wb);
        chk({req, " byte"}, {24'h0, got}, {24'h0, eb});
        chk({req, " R6 rep_flag"}, {31'h0, rf}, {31'h0, er});
        chk({req, " R7 drop_flag"}, {31'h0, df}, {31'h0, ed});
        bit_period(pick, 1'b0, 1'b0, 8'h00, smp);
        chk("R3 idle after slot", {31'h0, smp}, 32'h1);
    endtask

    initial begin
        logic smp;
        logic rf0;
        logic df0;
        repeat (3) @(negedge clk);
        // R1
        chk("R1 pcm_out", {31'h0, pcm_out}, 32'h1);
        chk("R1 rep_flag", {31'h0, rep_flag}, 32'h0);
        chk("R1 drop_flag", {31'h0, drop_flag}, 32'h0);
        rst_n = 1'b1;
        @(negedge clk);

        // R6: before any write the stored byte is FF and repeats
        read_slot("R6 first read", 1'b1, 1'b0, 8'h00);
        // R5 and R2: single byte, msb first
        write_byte(8'hA5);
        read_slot("R5 R2 one write", 1'b1, 1'b0, 8'h00);
        // R6: nothing new, same byte repeated
        read_slot("R6 repeat", 1'b0, 1'b0, 8'h00);
        // R7: three writes, newest wins
        write_byte(8'h12);
        write_byte(8'h34);
        write_byte(8'hC3);
        read_slot("R7 drop", 1'b0, 1'b0, 8'h00);
        // R8: write in the slot start cycle goes to the next slot
        write_byte(8'h5A);
        read_slot("R8 same cycle", 1'b1, 1'b1, 8'h81);
        read_slot("R8 next slot", 1'b1, 1'b0, 8'h00);

        // R4: strobe b while strobe a is selected starts nothing
        write_byte(8'h3C);
        ts_pick = 1'b1;
        rf0 = rep_flag;
        df0 = drop_flag;
        bit_period(1'b0, 1'b0, 1'b0, 8'h00, smp);
        for (int i = 0; i < 8; i++) begin
            bit_period(1'b0, 1'b1, 1'b0, 8'h00, smp);
            chk("R4 unselected strobe pcm_out", {31'h0, smp}, 32'h1);
        end
        ts_b = 1'b0;
        chk("R4 rep_flag unchanged", {31'h0, rep_flag}, {31'h0, rf0});
        chk("R4 drop_flag unchanged", {31'h0, drop_flag}, {31'h0, df0});
        read_slot("R4 selected strobe", 1'b1, 1'b0, 8'h00);

        // R9: blanking still consumes the byte
        write_byte(8'h00);
        write_byte(8'h0F);
        blank_req = 1'b1;
        @(negedge clk);
        chk("R9 immediate ones", {31'h0, pcm_out}, 32'h1);
        read_slot("R9 blank", 1'b1, 1'b0, 8'h00);
        blank_req = 1'b0;
        read_slot("R9 after blank", 1'b1, 1'b0, 8'h00);

        // R10: supervised alarm blanks, unsupervised alarm is ignored
        write_byte(8'h00);
        alarm_in = 1'b1;
        sup_n    = 1'b1;
        read_slot("R10 unsupervised", 1'b0, 1'b0, 8'h00);
        write_byte(8'h66);
        sup_n = 1'b0;
        read_slot("R10 supervised", 1'b0, 1'b0, 8'h00);
        alarm_in = 1'b0;
        sup_n    = 1'b1;

        // random mix
        begin
            int unsigned seed_dummy;
            seed_dummy = $urandom(32'd20240611);
        end
        for (int n = 0; n < 40; n++) begin
            int unsigned nw;
            nw = $urandom_range(0, 3);
            for (int k = 0; k < int'(nw); k++) begin
                write_byte(8'($urandom));
            end
            blank_req = ($urandom_range(0, 7) == 0);
            alarm_in  = $urandom_range(0, 1) == 1;
            sup_n     = $urandom_range(0, 1) == 1;
            read_slot("R2 R5 R10 random", 1'($urandom_range(0, 1)),
                      1'($urandom_range(0, 3) == 0), 8'($urandom));
            blank_req = 1'b0;
            alarm_in  = 1'b0;
            sup_n     = 1'b1;
        end

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule